// File: doc/BRIEF.md
# Peripheral Interrupt Mapper and Gate

This block sits between the peripheral interrupt request lines of a chip and the core's event controller. Each of the 64 request lines has a 4-bit routing field that picks one of nine general-purpose core event levels, numbered 7 to 15. Any number of sources may share one level. A per-source enable gates whether a request reaches its level. The output for each level is the OR of every enabled, asserting source routed to that level. Latching and nesting happen downstream in the core, so this block only routes live requests.

Software can read a live status word that shows which sources are asserting at that moment, whatever their enable state. With this word, a handler on a shared level can find the source that fired. A separate per-source wake enable drives one wake request for a sleeping core. The wake path does not depend on the routing enables. Some source positions are reserved: they never assert, and their status always reads zero.

All registers are 32 bits wide and sit behind a simple single-cycle write / combinational read port. The level outputs and the wake output are registered, so they follow the inputs one clock later.

Top module: `imap_top`

## Requirements
- R1: After reset, all enable bits and all wake-enable bits are 0, and all level outputs and the wake output are 0. Each routing field resets to source index divided by 8, limited to 8 at most: sources 0–7 read 0, 8–15 read 1, and so on, with 56–63 reading 7.
- R2: One clock after a source is asserting with its enable bit set, the level output with index equal to its routing value (that is, core level 7 + value) is 1. Each bit `lvl_req_o[k]` stands for core level 7 + k.
- R3: A source whose enable bit is 0 does not affect any level output.
- R4: Status words read the live request lines, with reserved positions forced to 0, and they ignore the enable bits. Writes to status addresses change no register.
- R5: One clock after the inputs, `wake_o` is the OR over all sources of request AND wake-enable. It is independent of the enable bits.
- R6: The routing field of source s occupies bits 4·(s mod 8)+3 down to 4·(s mod 8) of the word at address 8 + s/8. Routing values 9 to 15 reach no level.
- R7: Sources 49, 50 and 56 to 63 are reserved. Their request lines never affect any level output or the wake output, and their status bits read 0.
- R8: The register map is as follows. Address 0/1 holds the enable words and address 4/5 holds the wake-enable words; in both, bit j of word w is source 32·w+j. Address 2/3 holds the status words, laid out the same way. Addresses 6 and 7 read 0 and ignore writes. Written words read back unchanged.
- R9: Several asserting, enabled sources that share one routing value together drive a single 1 on that level, and that level stays 1 while any one of them still asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Peripheral request lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| lvl_req_o | output | 9 | Request per core level; bit k is level 7+k |
| wake_o | output | 1 | Wake request for a sleeping core |

## Verification
The bench uses the default parameters: 64 sources, 32-bit words, 4-bit fields and nine levels. These give two enable/status/wake words and eight routing words, with the reserved pattern in the upper word. At this size every address, both halves of the source space and the reserved positions can be reached. Routing values above the last level can also be reached, so random writes hit unused codes as well as values shared by several sources.

// File: rtl/imap_pkg.sv
package imap_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_MASK,
    RK_STAT,
    RK_WAKE,
    RK_ASG
  } reg_kind_e;
endpackage

// File: rtl/imap_regfile.sv
module imap_regfile
  import imap_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned NUM_LVL = 9,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] RSVD = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  input  logic [NUM_SRC-1:0]         irq_i,
  output logic [NUM_SRC-1:0]         mask_o,
  output logic [NUM_SRC-1:0]         wake_en_o,
  output logic [NUM_SRC*FIELD_W-1:0] asg_o
);
  localparam int unsigned NW      = NUM_SRC / REG_W;
  localparam int unsigned NA      = NUM_SRC * FIELD_W / REG_W;
  localparam int unsigned PER_REG = REG_W / FIELD_W;
  localparam int unsigned WI_W    = (NA > 1) ? $clog2(NA) : 1;

  function automatic logic [NUM_SRC*FIELD_W-1:0] asg_default();
    logic [NUM_SRC*FIELD_W-1:0] r;
    int unsigned f;
    r = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      f = s / PER_REG;
      if (f >= NUM_LVL) f = NUM_LVL - 1;
      r[s*FIELD_W +: FIELD_W] = FIELD_W'(f);
    end
    return r;
  endfunction

  localparam logic [NUM_SRC*FIELD_W-1:0] ASG_RST = asg_default();

  logic [NUM_SRC-1:0]         mask_q, wake_q, live;
  logic [NUM_SRC*FIELD_W-1:0] asg_q;
  reg_kind_e                  kind;
  logic [WI_W-1:0]            idx;

  assign live = irq_i & ~RSVD;

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (addr_i < ADDR_W'(NW)) begin
      kind = RK_MASK;
      idx  = WI_W'(addr_i);
    end else if (addr_i < ADDR_W'(2*NW)) begin
      kind = RK_STAT;
      idx  = WI_W'(addr_i - ADDR_W'(NW));
    end else if (addr_i < ADDR_W'(3*NW)) begin
      kind = RK_WAKE;
      idx  = WI_W'(addr_i - ADDR_W'(2*NW));
    end else if (addr_i >= ADDR_W'(NA)) begin
      kind = RK_ASG;
      idx  = WI_W'(addr_i - ADDR_W'(NA));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= '0;
      asg_q  <= ASG_RST;
    end else if (wr_en_i) begin
      case (kind)
        RK_MASK: mask_q[int'(idx)*REG_W +: REG_W] <= wdata_i;
        RK_WAKE: wake_q[int'(idx)*REG_W +: REG_W] <= wdata_i;
        RK_ASG:  asg_q[int'(idx)*REG_W +: REG_W]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      RK_MASK: rdata_o = mask_q[int'(idx)*REG_W +: REG_W];
      RK_STAT: rdata_o = live[int'(idx)*REG_W +: REG_W];
      RK_WAKE: rdata_o = wake_q[int'(idx)*REG_W +: REG_W];
      RK_ASG:  rdata_o = asg_q[int'(idx)*REG_W +: REG_W];
      default: rdata_o = '0;
    endcase
  end

  assign mask_o    = mask_q;
  assign wake_en_o = wake_q;
  assign asg_o     = asg_q;

  // R8: without a write strobe no register moves
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));

  // R4: status writes touch nothing
  a_r4_stat_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind == RK_STAT) |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));
endmodule

// File: rtl/imap_router.sv
module imap_router #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned NUM_LVL = 9,
  parameter logic [NUM_SRC-1:0] RSVD = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0]         irq_i,
  input  logic [NUM_SRC-1:0]         mask_i,
  input  logic [NUM_SRC-1:0]         wake_en_i,
  input  logic [NUM_SRC*FIELD_W-1:0] asg_i,
  output logic [NUM_LVL-1:0]         lvl_req_o,
  output logic                       wake_o
);
  logic [NUM_SRC-1:0] live, gated;
  logic [NUM_LVL-1:0] lvl_nxt;
  logic               wake_nxt;

  assign live  = irq_i & ~RSVD;
  assign gated = live & mask_i;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] hit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = gated[s] && (asg_i[s*FIELD_W +: FIELD_W] == FIELD_W'(l));
    end
    assign lvl_nxt[l] = |hit;
  end

  // wake ignores the routing enables
  assign wake_nxt = |(live & wake_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_req_o <= '0;
      wake_o    <= 1'b0;
    end else begin
      lvl_req_o <= lvl_nxt;
      wake_o    <= wake_nxt;
    end
  end

  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated == '0) |=> (lvl_req_o == '0));

  a_r2_req_has_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_req_o != '0) |-> $past(|gated));

  a_r5_wake_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(live & wake_en_i)) |=> wake_o);

  a_r5_wake_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((live & wake_en_i) == '0) |=> !wake_o);
endmodule

// File: rtl/imap_top.sv
module imap_top #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned NUM_LVL = 9,
  parameter logic [NUM_SRC-1:0] RSVD = 64'hFF06_0000_0000_0000,
  localparam int unsigned ADDR_W = $clog2(2 * NUM_SRC * FIELD_W / REG_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [NUM_LVL-1:0] lvl_req_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0]         mask, wake_en;
  logic [NUM_SRC*FIELD_W-1:0] asg;

  imap_regfile #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .FIELD_W(FIELD_W),
    .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W), .RSVD(RSVD)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_i    (irq_i),
    .mask_o   (mask),
    .wake_en_o(wake_en),
    .asg_o    (asg)
  );

  imap_router #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LVL(NUM_LVL), .RSVD(RSVD)
  ) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .mask_i   (mask),
    .wake_en_i(wake_en),
    .asg_i    (asg),
    .lvl_req_o(lvl_req_o),
    .wake_o   (wake_o)
  );
endmodule

// File: tb/imap_top_tb_top.sv
module imap_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  lvl;
  logic        wake;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;

  localparam logic [63:0] RSV = 64'hFF06_0000_0000_0000;

  logic [63:0]  m_mask, m_wake;
  logic [255:0] m_asg;

  imap_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .lvl_req_o(lvl), .wake_o(wake)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_lvl(input logic [63:0] r);
    logic [8:0] e = '0;
    for (int s = 0; s < 64; s++) begin
      if (r[s] && !RSV[s] && m_mask[s] && m_asg[s*4 +: 4] < 4'd9)
        e[m_asg[s*4 +: 4]] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic exp_wake(input logic [63:0] r);
    return |(r & ~RSV & m_wake);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [63:0] r);
    logic [63:0] st = r & ~RSV;
    case (a)
      4'd0: return m_mask[31:0];
      4'd1: return m_mask[63:32];
      4'd2: return st[31:0];
      4'd3: return st[63:32];
      4'd4: return m_wake[31:0];
      4'd5: return m_wake[63:32];
      4'd6, 4'd7: return 32'h0;
      default: return m_asg[(int'(a) - 8)*32 +: 32];
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      4'd0: m_mask[31:0] = d;
      4'd1: m_mask[63:32] = d;
      4'd4: m_wake[31:0] = d;
      4'd5: m_wake[63:32] = d;
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15:
        m_asg[(int'(a) - 8)*32 +: 32] = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [63:0] r);
    irq = r;
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [3:0] a, input string req);
    addr = a;
    #1;
    chk(rdata === exp_rd(a, irq), req, {32'h0, rdata}, {32'h0, exp_rd(a, irq)});
  endtask

  task automatic chk_out(input string req);
    chk(lvl === exp_lvl(irq), req, {55'h0, lvl}, {55'h0, exp_lvl(irq)});
    chk(wake === exp_wake(irq), req, {63'h0, wake}, {63'h0, exp_wake(irq)});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = '0; m_wake = '0;
    for (int s = 0; s < 64; s++) m_asg[s*4 +: 4] = 4'(s / 8);
    #35 rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8: reset contents and map
    chk_out("R1");
    for (int a = 0; a < 16; a++) chk_rd(4'(a), "R1");

    // R2 / R6: source 41 sits in routing word 5, value 5 -> level 12
    wr(4'd1, 32'h0000_0200);
    drive(64'h1 << 41);
    chk(lvl === 9'h020, "R2", {55'h0, lvl}, 64'h20);
    // R3: disable it while still asserting
    wr(4'd1, 32'h0);
    drive(irq);
    chk(lvl === 9'h0, "R3", {55'h0, lvl}, 64'h0);
    // R4: status is live despite disable
    chk_rd(4'd3, "R4");
    chk(rdata === 32'h0000_0200, "R4", {32'h0, rdata}, 64'h200);
    // R4: status write ignored
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    chk_rd(4'd0, "R4"); chk_rd(4'd1, "R4"); chk_rd(4'd4, "R4");
    chk_rd(4'd2, "R4"); chk_rd(4'd3, "R4");
    // R8: addresses 6/7 read zero after write
    wr(4'd6, 32'hA5A5_A5A5);
    chk_rd(4'd6, "R8"); chk_rd(4'd7, "R8");

    // R7: reserved sources with everything enabled
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
    drive(RSV);
    chk(lvl === 9'h0 && wake === 1'b0, "R7", {54'h0, wake, lvl}, 64'h0);
    chk_rd(4'd3, "R7");
    chk(rdata === 32'h0, "R7", {32'h0, rdata}, 64'h0);

    // R6: value 12 on source 3 reaches no level
    wr(4'd4, 32'h0); wr(4'd5, 32'h0);
    wr(4'd8, 32'h0000_C000);
    drive(64'h8);
    chk(lvl === 9'h0, "R6", {55'h0, lvl}, 64'h0);
    // R6: value 8 on source 3 -> level 15
    wr(4'd8, 32'h0000_8000);
    drive(64'h8);
    chk(lvl === 9'h100, "R6", {55'h0, lvl}, 64'h100);

    // R9: sources 0 and 1 share value 0
    drive(64'h3);
    chk(lvl === 9'h001, "R9", {55'h0, lvl}, 64'h1);
    drive(64'h2);
    chk(lvl === 9'h001, "R9", {55'h0, lvl}, 64'h1);
    drive(64'h0);
    chk(lvl === 9'h000, "R9", {55'h0, lvl}, 64'h0);

    // R5: wake with routing disabled
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    wr(4'd4, 32'h0000_0020);
    drive(64'h20);
    chk(wake === 1'b1 && lvl === 9'h0, "R5", {54'h0, wake, lvl}, 64'h200);
    drive(64'h10);
    chk(wake === 1'b0, "R5", {63'h0, wake}, 64'h0);

    // random mix: R2 R5 R8
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      if ($urandom % 2 == 0) wr(4'($urandom % 16), $urandom);
      r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      drive(r);
      chk_out("R2");
      chk_rd(4'($urandom % 16), "R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule